// File: doc/BRIEF.md
# Relative Reduce Index Sequencer

This block drives a scalar-reduce loop in which operand register numbers are set by distances rather than by the values the registers hold. A command names a base register, a second source register, a destination register, a vector length and an element mask. The block first packs the positions of the active mask bits into an ordered index list. It then walks that list and produces one triple of register numbers per step: first source, second source and destination. The distance of the second source and of the destination from the base register is applied through the index list, so masked elements are skipped.

With the destination equal to the base, the walk forms a running sum over the active elements. With the second source one register above the base, each step pairs neighbouring active elements. A reverse flag walks the same steps from the top of the range downward. Register reads and the arithmetic are left to the consumer, which takes triples over a valid/ready handshake. The block signals completion with a one-cycle pulse.

Top module: `rel_reduce_seq`

## Requirements
- R1: The source distance is the second-source register number minus the base register number, and the destination distance is the destination register number minus the base. Both are exact signed differences and either may be negative.
- R2: The index list holds, in ascending order, every position p with the mask bit p set and p below the vector length. Mask bits at or above the vector length are ignored.
- R3: With list length L, source distance s and destination distance d, the steps run over i from lo = max(0, -s, -d) up to but not including hi = L - max(0, s, d). Exactly hi - lo triples are emitted, so every list reference stays in range.
- R4: For step i the triple is first source = base + idx[i], second source = base + idx[i+s] and destination = base + idx[i+d], each taken modulo 2^REG_W.
- R5: With the reverse flag low, steps are emitted in ascending i. With the flag high, they are emitted in descending i, from hi-1 down to lo.
- R6: When hi - lo is zero or negative, no triple is emitted and done still pulses.
- R7: While valid is high and ready is low, valid stays high and the triple does not change. With ready held high, a new triple is offered every cycle.
- R8: done is high for exactly one cycle. It rises in the cycle after the final triple is accepted, or after setup for an empty walk. busy falls in that same cycle, and valid is low whenever busy is low.
- R9: A start pulse while busy is high has no effect on the command in progress.
- R10: Let k be the number of active elements and m = max(k,1). With ready held high, the first triple is valid m+4 rising edges after the edge that samples start. done is then seen m+4+N edges after that edge for N triples, or m+2 edges after it when N is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, taken only when idle |
| base_reg | input | REG_W | Base register number |
| src_reg | input | REG_W | Second-source register number |
| dst_reg | input | REG_W | Destination register number |
| vec_len | input | $clog2(MAX_VL+1) | Vector length, 0 to MAX_VL |
| pred_mask | input | MAX_VL | Element mask, bit p for element p |
| rev_order | input | 1 | Walk steps in descending order |
| busy | output | 1 | Command in progress |
| trip_valid | output | 1 | Triple available |
| trip_ready | input | 1 | Consumer accepts the triple |
| trip_ra | output | REG_W | First-source register number |
| trip_rb | output | REG_W | Second-source register number |
| trip_rt | output | REG_W | Destination register number |
| done | output | 1 | One-cycle completion pulse |

## Verification
A command takes one cycle to capture. The mask then takes m cycles to pack, setup takes one cycle, and the read-and-register pipeline takes two more. The first triple therefore appears m+4 edges after the sampling edge, and done follows one edge after the last accepted triple. The bench drives inputs and samples outputs on falling edges only. It counts rising edges from the edge that samples start, and it checks the latency figures only on runs with ready held high. On runs with an irregular ready pattern, the bench compares only handshaken triples against its arithmetic model. On those runs it also checks that a stalled triple is unchanged at the next falling edge.

// File: rtl/reduce_seq_pkg.sv
package reduce_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PACK  = 2'd1,
    ST_SETUP = 2'd2,
    ST_EMIT  = 2'd3
  } seq_state_e;

  localparam int NUM_RD_PORTS = 3;
endpackage

// File: rtl/rs_mask_compactor.sv
module rs_mask_compactor #(
  parameter int MAX_VL = 8,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              run,
  input  logic [MAX_VL-1:0] mask_in,
  input  logic [CNT_W-1:0]  vl_in,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [IDX_W-1:0]  wr_data,
  output logic              last,
  output logic [CNT_W-1:0]  len
);
  logic [MAX_VL-1:0] keep;
  logic [MAX_VL-1:0] resid;
  logic [CNT_W-1:0]  ptr;
  logic [IDX_W-1:0]  pos;
  logic              found;
  logic              single;

  for (genvar b = 0; b < MAX_VL; b++) begin : g_keep
    assign keep[b] = (vl_in > CNT_W'(b));
  end

  // lowest set bit wins
  always_comb begin
    pos = '0;
    for (int b = MAX_VL - 1; b >= 0; b--) begin
      if (resid[b]) pos = IDX_W'(b);
    end
  end

  assign found   = |resid;
  assign single  = ((resid & (resid - MAX_VL'(1))) == '0);
  assign wr_en   = run && found;
  assign wr_addr = ptr[IDX_W-1:0];
  assign wr_data = pos;
  assign last    = run && single;
  assign len     = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      resid <= '0;
      ptr   <= '0;
    end else if (load) begin
      resid <= mask_in & keep;
      ptr   <= '0;
    end else if (run && found) begin
      resid[pos] <= 1'b0;
      ptr        <= ptr + CNT_W'(1);
    end
  end

  AST_PACK_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_data > $past(wr_data))); // R2
endmodule

// File: rtl/rs_idx_bank.sv
module rs_idx_bank #(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int DW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rs_step_walker.sv
module rs_step_walker #(
  parameter int CNT_W = 4,
  parameter int IDX_W = 3,
  parameter int SW    = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  step,
  input  logic                  rev,
  input  logic [CNT_W-1:0]      len,
  input  logic signed [SW-1:0]  offs,
  input  logic signed [SW-1:0]  roffs,
  output logic                  empty,
  output logic [CNT_W-1:0]      remain,
  output logic [IDX_W-1:0]      addr_a,
  output logic [IDX_W-1:0]      addr_b,
  output logic [IDX_W-1:0]      addr_c
);
  localparam logic signed [SW-1:0] ONE = SW'(1);

  logic signed [SW-1:0] len_s, lo, lift, hi, span;
  logic signed [SW-1:0] cursor, pos_b, pos_c;

  always_comb begin
    len_s = $signed({{(SW-CNT_W){1'b0}}, len});
    lo = '0;
    if (-offs > lo)  lo = -offs;
    if (-roffs > lo) lo = -roffs;
    lift = '0;
    if (offs > lift)  lift = offs;
    if (roffs > lift) lift = roffs;
    hi    = len_s - lift;
    span  = hi - lo;
    empty = (span <= 0);
  end

  assign pos_b  = cursor + offs;
  assign pos_c  = cursor + roffs;
  assign addr_a = cursor[IDX_W-1:0];
  assign addr_b = pos_b[IDX_W-1:0];
  assign addr_c = pos_c[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cursor <= '0;
      remain <= '0;
    end else if (load) begin
      cursor <= rev ? (hi - ONE) : lo;
      remain <= empty ? '0 : span[CNT_W-1:0];
    end else if (step) begin
      cursor <= rev ? (cursor - ONE) : (cursor + ONE);
      remain <= remain - CNT_W'(1);
    end
  end

  AST_REF_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (remain != '0) |-> (cursor >= 0 && cursor < len_s && pos_b >= 0 &&
                        pos_b < len_s && pos_c >= 0 && pos_c < len_s)); // R3
endmodule

// File: rtl/rel_reduce_seq.sv
module rel_reduce_seq
  import reduce_seq_pkg::*;
#(
  parameter int REG_W  = 7,
  parameter int MAX_VL = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [REG_W-1:0]             base_reg,
  input  logic [REG_W-1:0]             src_reg,
  input  logic [REG_W-1:0]             dst_reg,
  input  logic [$clog2(MAX_VL+1)-1:0]  vec_len,
  input  logic [MAX_VL-1:0]            pred_mask,
  input  logic                         rev_order,
  output logic                         busy,
  output logic                         trip_valid,
  input  logic                         trip_ready,
  output logic [REG_W-1:0]             trip_ra,
  output logic [REG_W-1:0]             trip_rb,
  output logic [REG_W-1:0]             trip_rt,
  output logic                         done
);
  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;
  localparam int CNT_W = $clog2(MAX_VL + 1);
  localparam int SW    = ((REG_W > CNT_W) ? REG_W : CNT_W) + 2;

  seq_state_e state;
  logic [REG_W-1:0] ra_q, rb_q, rt_q;
  logic             rev_q;
  logic             done_q;

  logic signed [SW-1:0] offs, roffs;
  assign offs  = $signed({{(SW-REG_W){1'b0}}, rb_q}) - $signed({{(SW-REG_W){1'b0}}, ra_q});
  assign roffs = $signed({{(SW-REG_W){1'b0}}, rt_q}) - $signed({{(SW-REG_W){1'b0}}, ra_q});

  // packing
  logic             cmp_load, cmp_run, wr_en, cmp_last;
  logic [IDX_W-1:0] wr_addr, wr_data;
  logic [CNT_W-1:0] list_len;

  assign cmp_load = (state == ST_IDLE) && start;
  assign cmp_run  = (state == ST_PACK);

  rs_mask_compactor #(.MAX_VL(MAX_VL), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_pack (
    .clk     (clk),
    .rst     (rst),
    .load    (cmp_load),
    .run     (cmp_run),
    .mask_in (pred_mask),
    .vl_in   (vec_len),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .last    (cmp_last),
    .len     (list_len)
  );

  // walking
  logic             walk_empty, issue, advance, s1_v, out_v, final_hs;
  logic [CNT_W-1:0] remain;
  logic [IDX_W-1:0] addr_a, addr_b, addr_c;

  assign advance  = !out_v || trip_ready;
  assign issue    = (state == ST_EMIT) && advance && (remain != '0);
  assign final_hs = out_v && trip_ready && !s1_v && (remain == '0);

  rs_step_walker #(.CNT_W(CNT_W), .IDX_W(IDX_W), .SW(SW)) u_walk (
    .clk    (clk),
    .rst    (rst),
    .load   (state == ST_SETUP),
    .step   (issue),
    .rev    (rev_q),
    .len    (list_len),
    .offs   (offs),
    .roffs  (roffs),
    .empty  (walk_empty),
    .remain (remain),
    .addr_a (addr_a),
    .addr_b (addr_b),
    .addr_c (addr_c)
  );

  // one bank per read port, each written with the same list
  logic [IDX_W-1:0] rd_addr [NUM_RD_PORTS];
  logic [IDX_W-1:0] rd_data [NUM_RD_PORTS];
  assign rd_addr[0] = addr_a;
  assign rd_addr[1] = addr_b;
  assign rd_addr[2] = addr_c;

  for (genvar g = 0; g < NUM_RD_PORTS; g++) begin : g_bank
    rs_idx_bank #(.DEPTH(MAX_VL), .AW(IDX_W), .DW(IDX_W)) u_bank (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (wr_data),
      .re    (advance),
      .raddr (rd_addr[g]),
      .rdata (rd_data[g])
    );
  end

  // control
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      done_q <= 1'b0;
      ra_q   <= '0;
      rb_q   <= '0;
      rt_q   <= '0;
      rev_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          ra_q  <= base_reg;
          rb_q  <= src_reg;
          rt_q  <= dst_reg;
          rev_q <= rev_order;
          state <= ST_PACK;
        end
        ST_PACK: if (cmp_last) state <= ST_SETUP;
        ST_SETUP: begin
          if (walk_empty) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            state <= ST_EMIT;
          end
        end
        ST_EMIT: if (final_hs) begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // read stage and output register
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      out_v   <= 1'b0;
      trip_ra <= '0;
      trip_rb <= '0;
      trip_rt <= '0;
    end else if (advance) begin
      s1_v  <= issue;
      out_v <= s1_v;
      if (s1_v) begin
        trip_ra <= ra_q + REG_W'(rd_data[0]);
        trip_rb <= ra_q + REG_W'(rd_data[1]);
        trip_rt <= ra_q + REG_W'(rd_data[2]);
      end
    end
  end

  assign busy       = (state != ST_IDLE);
  assign trip_valid = out_v;
  assign done       = done_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (trip_valid && !trip_ready) |=> (trip_valid && $stable(trip_ra) &&
                                      $stable(trip_rb) && $stable(trip_rt))); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !trip_valid); // R8
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(ra_q) && $stable(rb_q) && $stable(rt_q) &&
                         $stable(rev_q))); // R9
endmodule

// File: tb/rel_reduce_seq_tb.sv
module rel_reduce_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W  = 7;
  localparam int MAX_VL = 8;
  localparam int CNT_W  = $clog2(MAX_VL + 1);
  localparam int RMOD   = 1 << REG_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [REG_W-1:0] base_reg = '0, src_reg = '0, dst_reg = '0;
  logic [CNT_W-1:0] vec_len = '0;
  logic [MAX_VL-1:0] pred_mask = '0;
  logic rev_order = 1'b0;
  logic busy, trip_valid, done;
  logic trip_ready = 1'b0;
  logic [REG_W-1:0] trip_ra, trip_rb, trip_rt;

  always #(CLK_PERIOD/2) clk = ~clk;

  rel_reduce_seq #(.REG_W(REG_W), .MAX_VL(MAX_VL)) dut_i (
    .clk(clk), .rst(rst), .start(start), .base_reg(base_reg),
    .src_reg(src_reg), .dst_reg(dst_reg), .vec_len(vec_len),
    .pred_mask(pred_mask), .rev_order(rev_order), .busy(busy),
    .trip_valid(trip_valid), .trip_ready(trip_ready), .trip_ra(trip_ra),
    .trip_rb(trip_rb), .trip_rt(trip_rt), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] lf = 16'hACE1;

  int e_trip [MAX_VL];
  int e_n, e_k;

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v,
                     input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp_v);
    end
  endtask

  function automatic int pack3(input int a, input int b, input int c);
    return (a << 16) | (b << 8) | c;
  endfunction

  // arithmetic model of R1 to R5
  task automatic build_model(input int ra, input int rb, input int rt, input int vl,
                             input logic [MAX_VL-1:0] m, input bit rv);
    int idx [MAX_VL];
    int len, s, d, lo, hi, i;
    len = 0;
    for (int b = 0; b < MAX_VL; b++) begin
      if (b < vl && m[b]) begin
        idx[len] = b;
        len++;
      end
    end
    s  = rb - ra;
    d  = rt - ra;
    lo = 0;
    if (-s > lo) lo = -s;
    if (-d > lo) lo = -d;
    hi = len;
    if (s > 0 && s >= d) hi = len - s;
    else if (d > 0) hi = len - d;
    e_n = hi - lo;
    if (e_n < 0) e_n = 0;
    e_k = len;
    for (int k = 0; k < e_n; k++) begin
      i = rv ? (hi - 1 - k) : (lo + k);
      e_trip[k] = pack3((ra + idx[i]) % RMOD, (ra + idx[i + s]) % RMOD,
                        (ra + idx[i + d]) % RMOD);
    end
  endtask

  task automatic run_one(input int ra, input int rb, input int rt, input int vl,
                         input logic [MAX_VL-1:0] m, input bit rv,
                         input bit steady, input bit restart);
    int edges, got, last_trip, m_cyc, exp_done;
    bit prev_stall, fin, rdy;
    string tag;
    build_model(ra, rb, rt, vl, m, rv);
    if (rv) tag = "R5";
    else if (vl < MAX_VL) tag = "R2";
    else if (rb < ra || rt < ra) tag = "R1";
    else tag = "R4";
    @(negedge clk);
    base_reg = REG_W'(ra); src_reg = REG_W'(rb); dst_reg = REG_W'(rt);
    vec_len = CNT_W'(vl); pred_mask = m; rev_order = rv;
    start = 1'b1; trip_ready = 1'b0;
    edges = 0; got = 0; prev_stall = 0; fin = 0; last_trip = 0;
    while (!fin) begin
      @(negedge clk);
      edges++;
      start = 1'b0;
      if (restart && edges == 2) begin
        start = 1'b1;               // R9: must not disturb this command
        base_reg = REG_W'(ra + 3);
        src_reg = REG_W'(ra);
        rev_order = !rv;
        pred_mask = ~m;
      end
      if (done) begin
        chk(got == e_n, (e_n == 0) ? "R6" : "R3", got, e_n, "triple count");
        chk(!busy, "R8", busy, 0, "busy with done");
        if (steady) begin
          m_cyc = (e_k > 1) ? e_k : 1;
          exp_done = (e_n > 0) ? (m_cyc + 4 + e_n) : (m_cyc + 2);
          chk(edges == exp_done, "R10", edges, exp_done, "done latency");
        end
        fin = 1;
      end else begin
        if (prev_stall)
          chk(trip_valid && pack3(trip_ra, trip_rb, trip_rt) == last_trip, "R7",
              pack3(trip_ra, trip_rb, trip_rt), last_trip, "stalled triple");
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        rdy = steady ? 1'b1 : (lf[0] | lf[1]);
        if (trip_valid && steady && got == 0) begin
          m_cyc = (e_k > 1) ? e_k : 1;
          chk(edges == m_cyc + 4, "R10", edges, m_cyc + 4, "first valid");
        end
        if (trip_valid && rdy) begin
          if (got < e_n)
            chk(pack3(trip_ra, trip_rb, trip_rt) == e_trip[got], tag,
                pack3(trip_ra, trip_rb, trip_rt), e_trip[got], "triple");
          else
            chk(1'b0, "R3", got + 1, e_n, "extra triple");
          got++;
        end
        prev_stall = trip_valid && !rdy;
        last_trip  = pack3(trip_ra, trip_rb, trip_rt);
        trip_ready = rdy;
        if (edges > 300) begin
          chk(1'b0, "R8", edges, 300, "run never finished");
          fin = 1;
        end
      end
    end
    trip_ready = 1'b0;
    @(negedge clk);
    chk(!done && !trip_valid, "R8", done, 0, "done pulse width");
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !trip_valid && !done, "R8",
        {busy, trip_valid, done}, 0, "reset state");

    // near-exhaustive sweep: every mask, six distance settings, both orders
    for (int cfg = 0; cfg < 6; cfg++) begin
      for (int mk = 0; mk < 256; mk++) begin
        for (int rv = 0; rv < 2; rv++) begin
          int ra, rb, rt, vl;
          case (cfg)
            0: begin ra = 10;  rb = 11;  rt = 10;  end  // running sum
            1: begin ra = 10;  rb = 12;  rt = 10;  end
            2: begin ra = 10;  rb = 9;   rt = 10;  end  // R1 negative source distance
            3: begin ra = 20;  rb = 21;  rt = 19;  end  // destination below base
            4: begin ra = 5;   rb = 5;   rt = 5;   end
            default: begin ra = 126; rb = 127; rt = 126; end  // R4 wrap
          endcase
          vl = (mk % 5 == 0) ? (mk % 9) : MAX_VL;
          run_one(ra, rb, rt, vl, MAX_VL'(mk), rv[0], (mk % 4 == 0), (mk % 7 == 3));
        end
      end
    end

    // R6: all masked, and distances too wide for the list
    run_one(30, 31, 30, 8, 8'h00, 1'b0, 1'b1, 1'b0);
    run_one(30, 37, 30, 8, 8'h7F, 1'b0, 1'b1, 1'b0);
    run_one(30, 30, 22, 8, 8'hFF, 1'b1, 1'b1, 1'b0);
    finish_up();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule